// File: doc/BRIEF.md
# Direct-Mapped Texel Line Cache

This block sits between the texture lookup stage of a polygon rasterizer and a frame buffer port that is 16 bits wide. Each lookup carries 8-bit texture coordinates (u,v) and a texel depth of 4, 8 or 16 bits. The block answers with the texel value and a flag that says whether the value came from the cache.

The cache is direct-mapped and has 256 lines. Each line holds a 6-bit block tag, a valid bit and 64 bits of texel data. The tag is a two-dimensional block number taken from the high bits of u and v, so it is not a linear address. The line index comes from the low bits of v and from the middle bits of u. How many bits each part gets depends on the depth: a line spans 16, 8 or 4 texels of one row. On a miss the block reads the four 16-bit words of the line from memory, one handshake per word. It then writes the line and answers the waiting lookup.

The caller must pulse the invalidate input whenever it changes the depth or the page base. A lookup is taken only while busy is low.

Top module: `tex_line_cache`

## Requirements
- R1: After reset every line is invalid and `busy`, `rd_valid`, `rd_hit` and `mem_req` are low, so the first lookup at any coordinate misses.
- R2: With `lk_mode`=0 (4-bit texels) the tag is {v[7:6],u[7:6]} and the index is {v[5:0],u[5:4]}. A line holds the 16 texels with u[7:4] equal in one row.
- R3: With `lk_mode`=1 (8-bit texels) the tag is {v[7:6],u[7:5]} and the index is {v[5:0],u[4:3]}. A line holds 8 texels.
- R4: With `lk_mode`=2 (16-bit texels; the value 3 acts the same) the tag is {v[7:5],u[7:5]} and the index is {v[4:0],u[4:2]}. A line holds 4 texels.
- R5: A lookup is accepted on a rising edge where `lk_valid` is high and `busy` is low. A lookup hits when the line at its index is valid and its tag equals the lookup's tag. On a hit, `rd_valid` and `rd_hit` are high in the cycle right after acceptance, together with the texel.
- R6: On a miss the block reads exactly four words. Word k (k=0..3) is at `page_base` + v*ROW_WORDS + C*4 + k, where C is u>>4, u>>3 or u>>2 for 4-, 8- or 16-bit texels. `mem_req` and `mem_addr` stay unchanged until the cycle in which `mem_ack` is high. `mem_data` is taken in that same cycle.
- R7: One cycle after the fourth acknowledge, the block presents `rd_valid` high with `rd_hit` low and the requested texel. The line is then resident, so a later lookup of the same line hits.
- R8: Word k fills bits [16k+15:16k] of the line. The texel is the nibble at u[3:0], the byte at u[2:0] or the halfword at u[1:0], with the lowest u in the least significant bits. It is zero-extended on `rd_texel`.
- R9: Two coordinates with the same index but different tags evict each other, even when both lie inside a region smaller than one block.
- R10: Lines with different indices stay resident together whatever their tags.
- R11: A cycle with `inval` high clears every valid bit, so every later lookup misses until its line is fetched again.
- R12: `busy` is high from the cycle after a missing lookup is accepted until the miss response has been given. While `busy` is high, `lk_valid` is ignored and `mem_req` is low whenever `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inval | input | 1 | Clears all valid bits |
| page_base | input | ADDR_W | Word address of the texture page origin |
| lk_valid | input | 1 | Lookup request |
| lk_mode | input | 2 | Texel depth: 0 = 4-bit, 1 = 8-bit, 2/3 = 16-bit |
| lk_u | input | 8 | Texel column |
| lk_v | input | 8 | Texel row |
| busy | output | 1 | Lookup not accepted this cycle |
| rd_valid | output | 1 | Response present |
| rd_hit | output | 1 | Response came from the cache |
| rd_texel | output | 16 | Texel value, zero-extended |
| mem_req | output | 1 | Word read request |
| mem_addr | output | ADDR_W | Word read address |
| mem_ack | input | 1 | Word read acknowledge, data valid |
| mem_data | input | 16 | Word read data |

## Verification
The assertions rely on the memory side answering every request in time. They also rely on `inval` never being raised while a fill is running, and on depth and page base changing only together with an invalidate. The bench's memory model acknowledges after zero, one or two idle cycles in rotation and returns a data value computed from the address. The bench pulses `inval` only between lookups and only while `busy` is low. During a fill it keeps `lk_valid` high only in the test that checks that requests are ignored while busy.

// File: rtl/tlc_pkg.sv
package tlc_pkg;
  localparam int COORD_W = 8;
  localparam int IDX_W   = 8;
  localparam int TAG_W   = 6;
  localparam int WORD_W  = 16;
  localparam int WORDS   = 4;
  localparam int LINE_W  = WORD_W * WORDS;
  localparam int LINES   = 1 << IDX_W;
  localparam int COL_W   = 8;
  localparam int K_W     = $clog2(WORDS);

  typedef enum logic [1:0] {
    DEPTH4  = 2'd0,
    DEPTH8  = 2'd1,
    DEPTH16 = 2'd2
  } depth_e;

  typedef enum logic [1:0] {
    F_IDLE  = 2'd0,
    F_FETCH = 2'd1,
    F_RESP  = 2'd2
  } fill_st_e;
endpackage

// File: rtl/tlc_map.sv
module tlc_map
  import tlc_pkg::*;
(
  input  logic [1:0]         mode,
  input  logic [COORD_W-1:0] u,
  input  logic [COORD_W-1:0] v,
  output logic [IDX_W-1:0]   idx,
  output logic [TAG_W-1:0]   tag,
  output logic [COL_W-1:0]   col
);
  always_comb begin
    unique case (mode)
      DEPTH4: begin
        tag = {2'b00, v[7:6], u[7:6]};
        idx = {v[5:0], u[5:4]};
        col = {2'b00, u[7:4], 2'b00};
      end
      DEPTH8: begin
        tag = {1'b0, v[7:6], u[7:5]};
        idx = {v[5:0], u[4:3]};
        col = {1'b0, u[7:3], 2'b00};
      end
      default: begin
        tag = {v[7:5], u[7:5]};
        idx = {v[4:0], u[4:2]};
        col = {u[7:2], 2'b00};
      end
    endcase
  end
endmodule

// File: rtl/tlc_ram.sv
module tlc_ram #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 70,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/tlc_valid.sv
module tlc_valid #(
  parameter int N = 256,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          set,
  input  logic [AW-1:0] sidx,
  input  logic          re,
  input  logic [AW-1:0] ridx,
  output logic          q
);
  logic [N-1:0] bits_q;

  always_ff @(posedge clk) begin
    if (rst || clr)  bits_q <= '0;
    else if (set)    bits_q[sidx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)       q <= 1'b0;
    else if (re)   q <= clr ? 1'b0 : bits_q[ridx];
  end
endmodule

// File: rtl/tlc_fill.sv
module tlc_fill
  import tlc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_data,
  output logic              mem_req,
  output logic [K_W-1:0]    k,
  output logic              resp,
  output logic              active,
  output logic [LINE_W-1:0] line
);
  fill_st_e          st_q;
  logic [K_W-1:0]    k_q;
  logic [WORD_W-1:0] buf_q [WORDS];

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= F_IDLE;
      k_q  <= '0;
    end else begin
      unique case (st_q)
        F_IDLE: if (start) begin
          st_q <= F_FETCH;
          k_q  <= '0;
        end
        F_FETCH: if (mem_ack) begin
          if (k_q == K_W'(WORDS - 1)) st_q <= F_RESP;
          else                        k_q  <= k_q + 1'b1;
        end
        default: st_q <= F_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st_q == F_FETCH && mem_ack) buf_q[k_q] <= mem_data;
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_line
    assign line[w*WORD_W +: WORD_W] = buf_q[w];
  end

  assign mem_req = (st_q == F_FETCH);
  assign resp    = (st_q == F_RESP);
  assign active  = (st_q != F_IDLE);
  assign k       = k_q;
endmodule

// File: rtl/tlc_pick.sv
module tlc_pick
  import tlc_pkg::*;
(
  input  logic [LINE_W-1:0] line,
  input  logic [1:0]        mode,
  input  logic [3:0]        ulo,
  output logic [WORD_W-1:0] texel
);
  always_comb begin
    unique case (mode)
      DEPTH4:  texel = {12'd0, line[{ulo, 2'b00} +: 4]};
      DEPTH8:  texel = {8'd0,  line[{ulo[2:0], 3'b000} +: 8]};
      default: texel = line[{ulo[1:0], 4'b0000} +: 16];
    endcase
  end
endmodule

// File: rtl/tex_line_cache.sv
module tex_line_cache
  import tlc_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int ROW_WORDS = 1024
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inval,
  input  logic [ADDR_W-1:0]  page_base,
  input  logic               lk_valid,
  input  logic [1:0]         lk_mode,
  input  logic [COORD_W-1:0] lk_u,
  input  logic [COORD_W-1:0] lk_v,
  output logic               busy,
  output logic               rd_valid,
  output logic               rd_hit,
  output logic [WORD_W-1:0]  rd_texel,
  output logic               mem_req,
  output logic [ADDR_W-1:0]  mem_addr,
  input  logic               mem_ack,
  input  logic [WORD_W-1:0]  mem_data
);
  localparam int ENT_W = TAG_W + LINE_W;
  localparam logic [ADDR_W-1:0] ROW_STRIDE = ADDR_W'(ROW_WORDS);

  logic              accept;
  logic [IDX_W-1:0]  in_idx;
  logic [TAG_W-1:0]  in_tag;
  logic [COL_W-1:0]  in_col;

  logic               s1_vld;
  logic [1:0]         s1_mode;
  logic [COORD_W-1:0] s1_u, s1_v;
  logic [IDX_W-1:0]   s1_idx;
  logic [TAG_W-1:0]   s1_tag;
  logic [COL_W-1:0]   s1_col;

  logic [ENT_W-1:0]  ram_q;
  logic              vld_q;
  logic              hit_c, miss_c;
  logic              f_resp, f_active;
  logic [K_W-1:0]    f_k;
  logic [LINE_W-1:0] f_line;

  assign accept = lk_valid && !busy;

  tlc_map map_i (
    .mode (lk_mode), .u(lk_u), .v(lk_v),
    .idx  (in_idx),  .tag(in_tag), .col(in_col)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld  <= 1'b0;
      s1_mode <= '0;
      s1_u    <= '0;
      s1_v    <= '0;
      s1_idx  <= '0;
      s1_tag  <= '0;
      s1_col  <= '0;
    end else begin
      s1_vld <= accept;
      if (accept) begin
        s1_mode <= lk_mode;
        s1_u    <= lk_u;
        s1_v    <= lk_v;
        s1_idx  <= in_idx;
        s1_tag  <= in_tag;
        s1_col  <= in_col;
      end
    end
  end

  tlc_ram #(.DEPTH(LINES), .WIDTH(ENT_W)) ram_i (
    .clk   (clk),
    .we    (f_resp),
    .waddr (s1_idx),
    .wdata ({s1_tag, f_line}),
    .re    (accept),
    .raddr (in_idx),
    .rdata (ram_q)
  );

  tlc_valid #(.N(LINES)) valid_i (
    .clk  (clk),
    .rst  (rst),
    .clr  (inval),
    .set  (f_resp),
    .sidx (s1_idx),
    .re   (accept),
    .ridx (in_idx),
    .q    (vld_q)
  );

  assign hit_c  = s1_vld && vld_q && (ram_q[LINE_W +: TAG_W] == s1_tag);
  assign miss_c = s1_vld && !hit_c;

  tlc_fill fill_i (
    .clk      (clk),
    .rst      (rst),
    .start    (miss_c),
    .mem_ack  (mem_ack),
    .mem_data (mem_data),
    .mem_req  (mem_req),
    .k        (f_k),
    .resp     (f_resp),
    .active   (f_active),
    .line     (f_line)
  );

  assign mem_addr = page_base + ADDR_W'(s1_v) * ROW_STRIDE
                  + ADDR_W'(s1_col) + ADDR_W'(f_k);

  tlc_pick pick_i (
    .line  (f_resp ? f_line : ram_q[LINE_W-1:0]),
    .mode  (s1_mode),
    .ulo   (s1_u[3:0]),
    .texel (rd_texel)
  );

  assign busy     = miss_c || f_active;
  assign rd_valid = hit_c || f_resp;
  assign rd_hit   = hit_c;
endmodule

// File: rtl/tlc_chk.sv
module tlc_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              lk_valid,
  input logic              busy,
  input logic              rd_valid,
  input logic              rd_hit,
  input logic              mem_req,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr
);
  logic [2:0] ack_cnt;

  always_ff @(posedge clk) begin
    if (rst)                         ack_cnt <= '0;
    else if (rd_valid && !rd_hit)    ack_cnt <= '0;
    else if (mem_req && mem_ack)     ack_cnt <= ack_cnt + 1'b1;
  end

  AST_HIT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && !busy) |=> (busy || (rd_valid && rd_hit))); // R5

  AST_HIT_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    rd_hit |-> (rd_valid && !busy)); // R5

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R6

  AST_FOUR_WORDS: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_hit) |-> (ack_cnt == 3'd4)); // R6

  AST_MISS_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_hit) |-> $past(mem_req && mem_ack)); // R7

  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req); // R12
endmodule

bind tex_line_cache tlc_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .lk_valid (lk_valid),
  .busy     (busy),
  .rd_valid (rd_valid),
  .rd_hit   (rd_hit),
  .mem_req  (mem_req),
  .mem_ack  (mem_ack),
  .mem_addr (mem_addr)
);

// File: tb/tex_line_cache_tb.sv
module tex_line_cache_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 20;
  localparam int ROW_WORDS  = 1024;
  localparam logic [ADDR_W-1:0] BASE = 20'h12340;

  // {inval, mode[1:0], u[7:0], v[7:0], exp_hit}
  localparam int NV = 24;
  localparam logic [19:0] VEC [NV] = '{
    {1'b1, 2'd0, 8'd0,   8'd0,   1'b0},   // R1 R2 first access misses
    {1'b0, 2'd0, 8'd5,   8'd0,   1'b1},   // R2 same 16-texel line
    {1'b0, 2'd0, 8'd15,  8'd0,   1'b1},   // R2 line end
    {1'b0, 2'd0, 8'd16,  8'd0,   1'b0},   // R2 next line
    {1'b0, 2'd0, 8'd64,  8'd0,   1'b0},   // R9 same index, tag 1
    {1'b0, 2'd0, 8'd3,   8'd0,   1'b0},   // R9 evicted
    {1'b0, 2'd0, 8'd7,   8'd9,   1'b0},
    {1'b0, 2'd0, 8'd90,  8'd70,  1'b0},
    {1'b0, 2'd0, 8'd7,   8'd9,   1'b1},   // R10 coexist
    {1'b0, 2'd0, 8'd81,  8'd70,  1'b1},   // R10 coexist
    {1'b0, 2'd0, 8'd200, 8'd250, 1'b0},
    {1'b0, 2'd0, 8'd207, 8'd250, 1'b1},
    {1'b1, 2'd1, 8'd40,  8'd3,   1'b0},   // R3
    {1'b0, 2'd1, 8'd47,  8'd3,   1'b1},   // R3
    {1'b0, 2'd1, 8'd8,   8'd3,   1'b0},   // R3 same index, tag 0
    {1'b0, 2'd1, 8'd40,  8'd3,   1'b0},   // R3 evicted
    {1'b0, 2'd1, 8'd44,  8'd3,   1'b1},
    {1'b1, 2'd2, 8'd37,  8'd33,  1'b0},   // R4
    {1'b0, 2'd2, 8'd38,  8'd33,  1'b1},   // R4
    {1'b0, 2'd2, 8'd5,   8'd1,   1'b0},   // R4 same index, tag 0
    {1'b0, 2'd2, 8'd37,  8'd33,  1'b0},   // R4 evicted
    {1'b0, 2'd2, 8'd39,  8'd33,  1'b1},
    {1'b0, 2'd2, 8'd255, 8'd255, 1'b0},   // R4 top index and tag
    {1'b0, 2'd2, 8'd252, 8'd255, 1'b1}
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              inval = 1'b0;
  logic [ADDR_W-1:0] page_base = BASE;
  logic              lk_valid = 1'b0;
  logic [1:0]        lk_mode = '0;
  logic [7:0]        lk_u = '0, lk_v = '0;
  logic              busy, rd_valid, rd_hit, mem_req;
  logic [15:0]       rd_texel;
  logic [ADDR_W-1:0] mem_addr;
  logic              mem_ack = 1'b0;
  logic [15:0]       mem_data = '0;

  int n_chk = 0;
  int n_fail = 0;
  int log_n = 0;
  logic [ADDR_W-1:0] addr_log [4];
  int ack_wait = 0;
  int ack_seq = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tex_line_cache #(.ADDR_W(ADDR_W), .ROW_WORDS(ROW_WORDS)) dut_i (
    .clk(clk), .rst(rst), .inval(inval), .page_base(page_base),
    .lk_valid(lk_valid), .lk_mode(lk_mode), .lk_u(lk_u), .lk_v(lk_v),
    .busy(busy), .rd_valid(rd_valid), .rd_hit(rd_hit), .rd_texel(rd_texel),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_data(mem_data)
  );

  function automatic logic [15:0] mem_f(input logic [ADDR_W-1:0] a);
    logic [31:0] p;
    p = 32'(a) * 32'd40503;
    return p[15:0] ^ p[27:12];
  endfunction

  function automatic logic [ADDR_W-1:0] row_addr(input logic [7:0] v);
    return BASE + ADDR_W'(v) * ADDR_W'(ROW_WORDS);
  endfunction

  function automatic logic [15:0] exp_texel(input logic [1:0] m, input logic [7:0] u, input logic [7:0] v);
    logic [15:0] w;
    if (m == 2'd0) begin
      w = mem_f(row_addr(v) + ADDR_W'(u >> 2));
      return (w >> (4 * u[1:0])) & 16'h000F;
    end else if (m == 2'd1) begin
      w = mem_f(row_addr(v) + ADDR_W'(u >> 1));
      return (w >> (8 * u[0])) & 16'h00FF;
    end
    return mem_f(row_addr(v) + ADDR_W'(u));
  endfunction

  function automatic logic [ADDR_W-1:0] exp_start(input logic [1:0] m, input logic [7:0] u, input logic [7:0] v);
    int sh;
    sh = (m == 2'd0) ? 4 : (m == 2'd1) ? 3 : 2;
    return row_addr(v) + ADDR_W'((u >> sh) * 4);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // memory model: acknowledges after 0, 1 or 2 idle cycles in rotation
  initial begin
    forever begin
      @(negedge clk);
      mem_ack = 1'b0;
      if (mem_req) begin
        if (ack_wait == 0) begin
          mem_ack  = 1'b1;
          mem_data = mem_f(mem_addr);
          if (log_n < 4) addr_log[log_n] = mem_addr;
          log_n++;
          ack_seq++;
          ack_wait = ack_seq % 3;
        end else begin
          ack_wait--;
        end
      end
    end
  end

  task automatic pulse_inval;
    @(negedge clk);
    while (busy) @(negedge clk);
    inval = 1'b1;
    @(negedge clk);
    inval = 1'b0;
  endtask

  task automatic look(input logic [1:0] m, input logic [7:0] u, input logic [7:0] v,
                      input bit exp_hit, input string req);
    int guard;
    @(negedge clk);
    while (busy) @(negedge clk);
    log_n    = 0;
    lk_mode  = m;
    lk_u     = u;
    lk_v     = v;
    lk_valid = 1'b1;
    @(negedge clk);
    lk_valid = 1'b0;
    if (exp_hit) begin
      check(rd_valid && rd_hit, req, {30'd0, rd_valid, rd_hit}, 32'h3);
      check(rd_texel == exp_texel(m, u, v), req, 32'(rd_texel), 32'(exp_texel(m, u, v)));
      guard = 0;
      while (busy && guard < 100) begin @(negedge clk); guard++; end
    end else begin
      check(!rd_valid && busy, req, {30'd0, rd_valid, busy}, 32'h1);
      guard = 0;
      while (!rd_valid && guard < 100) begin @(negedge clk); guard++; end
      check(rd_valid && !rd_hit, req, {30'd0, rd_valid, rd_hit}, 32'h2);
      check(rd_texel == exp_texel(m, u, v), req, 32'(rd_texel), 32'(exp_texel(m, u, v)));
      check(log_n == 4, "R6 word count", 32'(log_n), 32'd4);
      for (int k = 0; k < 4; k++)
        check(addr_log[k] == exp_start(m, u, v) + ADDR_W'(k), "R6 fill address",
              32'(addr_log[k]), 32'(exp_start(m, u, v) + ADDR_W'(k)));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    report();
    $finish;
  end

  initial begin
    int guard;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check({busy, rd_valid, rd_hit, mem_req} == 4'b0000, "R1 reset outputs",
          {28'd0, busy, rd_valid, rd_hit, mem_req}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][19]) pulse_inval();
      look(VEC[i][18:17], VEC[i][16:9], VEC[i][8:1], VEC[i][0], $sformatf("R5 R7 R8 vector %0d", i));
    end

    // R12: lookups held high during a fill are ignored
    pulse_inval();
    @(negedge clk);
    log_n    = 0;
    lk_mode  = 2'd0;
    lk_u     = 8'd100;
    lk_v     = 8'd100;
    lk_valid = 1'b1;
    @(negedge clk);
    lk_u = 8'd200;
    lk_v = 8'd7;
    check(busy, "R12 busy after miss", {31'd0, busy}, 32'd1);
    guard = 0;
    while (!rd_valid && guard < 100) begin @(negedge clk); guard++; end
    lk_valid = 1'b0;
    check(!rd_hit && rd_texel == exp_texel(2'd0, 8'd100, 8'd100), "R12 response for first lookup",
          32'(rd_texel), 32'(exp_texel(2'd0, 8'd100, 8'd100)));
    check(log_n == 4, "R12 one fill only", 32'(log_n), 32'd4);
    @(negedge clk);
    check(!busy && !rd_valid && !mem_req, "R12 held request dropped",
          {29'd0, busy, rd_valid, mem_req}, 32'h0);
    look(2'd0, 8'd100, 8'd100, 1'b1, "R12 first line resident");
    look(2'd0, 8'd200, 8'd7, 1'b0, "R12 ignored lookup not fetched");

    // R11: invalidate clears resident lines
    look(2'd0, 8'd110, 8'd100, 1'b1, "R11 resident before clear");
    pulse_inval();
    look(2'd0, 8'd110, 8'd100, 1'b0, "R11 miss after clear");
    look(2'd0, 8'd200, 8'd7, 1'b0, "R11 second line cleared");

    repeat (3) @(negedge clk);
    report();
    $finish;
  end
endmodule